// File: doc/BRIEF.md
# Dual-Bank Priority Interrupt Controller

This block gathers 32 interrupt request inputs and presents them to a processor on two independent output lines: a normal request line and a fast request line. Every input first passes a per-source polarity stage, then an optional latch that holds a short pulse until software acknowledges it. Each of the two banks has its own enable mask, which is changed through separate set and clear registers. Each bank also has a 4-bit priority ceiling, so that only sources whose priority is at or above a chosen urgency can reach that bank.

Software works through a 32-bit register bus with address, write strobe, read strobe and data. A handler polls the bank status word until it reads zero. On each pass it reads the bank's current-source register to learn which source to service. A read of the acknowledge register clears every latched request. Within a bank, the source with the numerically smallest priority value wins. Among sources with equal priority, the lowest index wins.

Top module: `prio_intc`

## Requirements
- R1: A write takes effect on the clock edge where `busWr` is high. Read data appears on `busRdata` in the cycle after the edge where `busRd` is high, and `busRdata` is zero in cycles with no read. A read at any address outside the map returns zero. The map covers bank offsets 0x00, 0x04, 0x08, 0x0C, 0x20, 0x28 and 0x2C in both banks, plus 0x200, 0x204 and 0x300–0x37C.
- R2: After reset the following values hold: both enable masks are 0, all priority words are 0, the polarity word (0x200) is all ones, the latch-select word (0x204) is 0, both ceilings are 0xF, and both outputs are low.
- R3: Writing bank offset 0x08 sets the mask bits where the data has ones. Writing bank offset 0x0C clears the mask bits where the data has ones. Zero bits leave the mask unchanged. A read of offset 0x08 returns the mask.
- R4: Bit n of the polarity word at 0x200 controls input n: a 1 passes the input unchanged and a 0 inverts it. Bank offset 0x04 reads the corrected inputs, whatever the enable state.
- R5: Bit n of the latch-select word at 0x204 controls how source n is held. A 0 makes the source follow its corrected input. A 1 holds a corrected high from the following edge until it is acknowledged.
- R6: A read of bank offset 0x28 returns the same value as the current-source register. On that edge it clears every held request. A source whose corrected input is still high stays pending.
- R7: A source qualifies in a bank when it is pending, enabled in that bank, and its priority value is at most the bank ceiling. Bank offset 0x00 reads the vector of qualifying sources.
- R8: Bank offset 0x20 returns the index of the qualifying source with the smallest priority value, taking the lower index on a tie. It returns 0 when no source qualifies.
- R9: The bank at 0x000 drives `irqOut` and the bank at 0x100 drives `fiqOut`. Each output is high in the cycle after an edge at which its bank had at least one qualifying source. The two banks never affect each other's mask or ceiling.
- R10: The priority of source n is the low 4 bits of the word at 0x300 + 4·n. It reads back with zero upper bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | 32 | Interrupt request inputs, already synchronous |
| busAddr | input | 10 | Byte address of the register access |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, one cycle after the read strobe |
| irqOut | output | 1 | Normal-bank request line |
| fiqOut | output | 1 | Fast-bank request line |

## Verification
The hardest condition to reach is a held request being cleared while other things happen in the same cycle. An acknowledge read can land on the same edge as a new input pulse, or as a change to the latch-select or polarity word. The resulting pending state then depends on which old and which new values the latch uses. The random phase therefore mixes acknowledge reads with single-cycle input pulses and with rewrites of the polarity and latch-select words. A directed sequence first pulses a latched source and drops it, and checks that it remains pending. It then acknowledges the source and checks that the pending state is gone.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_SRC = 32;
  localparam int PRIO_W  = 4;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 10;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int NUM_BANK = 2;

  // offsets inside one bank window
  localparam logic [7:0] OFS_STATUS = 8'h00;
  localparam logic [7:0] OFS_RAW    = 8'h04;
  localparam logic [7:0] OFS_ENSET  = 8'h08;
  localparam logic [7:0] OFS_ENCLR  = 8'h0C;
  localparam logic [7:0] OFS_CUR    = 8'h20;
  localparam logic [7:0] OFS_ACK    = 8'h28;
  localparam logic [7:0] OFS_CEIL   = 8'h2C;
  // offsets inside the shared window at 0x200
  localparam logic [7:0] OFS_POL    = 8'h00;
  localparam logic [7:0] OFS_STK    = 8'h04;

  typedef enum logic [3:0] {
    RD_NONE, RD_STATUS, RD_RAW, RD_MASK, RD_CUR,
    RD_CEIL, RD_POL, RD_STK, RD_PRIO
  } rdSel_e;

  typedef struct packed {
    logic [NUM_BANK-1:0] enSet;
    logic [NUM_BANK-1:0] enClr;
    logic [NUM_BANK-1:0] ceilWr;
    logic [NUM_BANK-1:0] ack;
    logic                polWr;
    logic                stkWr;
    logic                prioWr;
    logic [IDX_W-1:0]    prioIdx;
    logic                rdEn;
    rdSel_e              rdSel;
    logic                rdBank;
  } strobe_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int ADDR_BITS = ADDR_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_BITS-1:0] busAddr,
  input  logic                 busWr,
  input  logic                 busRd,
  output strobe_t              str
);
  localparam int REGION_LSB = 8;

  logic [1:0] region;
  logic [7:0] offset;
  logic       bank;

  assign region = busAddr[REGION_LSB+1:REGION_LSB];
  assign offset = {busAddr[7:2], 2'b00};
  assign bank   = busAddr[REGION_LSB];

  always_comb begin
    str        = '0;
    str.rdSel  = RD_NONE;
    str.rdEn   = busRd;
    str.rdBank = bank;
    unique case (region)
      2'd0, 2'd1: begin
        unique case (offset)
          OFS_STATUS: str.rdSel = RD_STATUS;
          OFS_RAW:    str.rdSel = RD_RAW;
          OFS_ENSET: begin
            str.rdSel       = RD_MASK;
            str.enSet[bank] = busWr;
          end
          OFS_ENCLR:  str.enClr[bank] = busWr;
          OFS_CUR:    str.rdSel = RD_CUR;
          OFS_ACK: begin
            str.rdSel     = RD_CUR;
            str.ack[bank] = busRd;
          end
          OFS_CEIL: begin
            str.rdSel        = RD_CEIL;
            str.ceilWr[bank] = busWr;
          end
          default: ;
        endcase
      end
      2'd2: begin
        if (offset == OFS_POL) begin
          str.rdSel = RD_POL;
          str.polWr = busWr;
        end else if (offset == OFS_STK) begin
          str.rdSel = RD_STK;
          str.stkWr = busWr;
        end
      end
      default: begin
        if (!offset[7]) begin
          str.rdSel   = RD_PRIO;
          str.prioIdx = offset[IDX_W+1:2];
          str.prioWr  = busWr;
        end
      end
    endcase
  end

  // R1: one bus access never updates two register groups
  a_r1_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({str.enSet, str.enClr, str.ceilWr, str.polWr, str.stkWr, str.prioWr}));

  // R6: an acknowledge only comes from a read
  a_r6_ack_on_read: assert property (@(posedge clk) disable iff (!rstN)
    (|str.ack) |-> busRd);
endmodule

// File: rtl/intc_arb.sv
module intc_arb
  import intc_pkg::*;
#(
  parameter int NSRC  = NUM_SRC,
  parameter int PW    = PRIO_W,
  parameter int IW    = $clog2(NSRC)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NSRC-1:0]         qual,
  input  logic [NSRC-1:0][PW-1:0] prio,
  output logic                    anyHit,
  output logic [IW-1:0]           winIdx
);
  logic [PW-1:0] bestP;

  always_comb begin
    anyHit = 1'b0;
    winIdx = '0;
    bestP  = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (qual[i] && (!anyHit || prio[i] < bestP)) begin
        anyHit = 1'b1;
        winIdx = IW'(i);
        bestP  = prio[i];
      end
    end
  end

  // R8: the chosen source qualifies
  a_r8_winner_qualifies: assert property (@(posedge clk) disable iff (!rstN)
    anyHit |-> qual[winIdx]);

  // R8: no qualifying source beats the winner on priority or on index
  for (genvar g = 0; g < NSRC; g++) begin : g_rank
    a_r8_best_wins: assert property (@(posedge clk) disable iff (!rstN)
      (anyHit && qual[g]) |->
        (prio[g] > prio[winIdx] || (prio[g] == prio[winIdx] && IW'(g) >= winIdx)));
  end
endmodule

// File: rtl/intc_dp.sv
module intc_dp
  import intc_pkg::*;
#(
  parameter int NSRC  = NUM_SRC,
  parameter int PW    = PRIO_W,
  parameter int DW    = DATA_W,
  parameter int NB    = NUM_BANK,
  parameter int IW    = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         str,
  input  logic [NSRC-1:0] srcIn,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic [NB-1:0]   bankOut
);
  logic [NSRC-1:0]         polSel;
  logic [NSRC-1:0]         stkSel;
  logic [NSRC-1:0]         held;
  logic [NSRC-1:0][PW-1:0] prio;
  logic [NB-1:0][NSRC-1:0] enMask;
  logic [NB-1:0][PW-1:0]   ceil;

  logic [NSRC-1:0]         corr;
  logic [NSRC-1:0]         pending;
  logic [NB-1:0][NSRC-1:0] qual;
  logic [NB-1:0]           anyHit;
  logic [NB-1:0][IW-1:0]   winIdx;
  logic [DW-1:0]           rdMux;

  assign corr    = srcIn ^ ~polSel;
  assign pending = corr | (held & stkSel);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [NSRC-1:0] inCeil;
    for (genvar i = 0; i < NSRC; i++) begin : g_ceil
      assign inCeil[i] = (prio[i] <= ceil[b]);
    end
    assign qual[b] = pending & enMask[b] & inCeil;

    intc_arb #(.NSRC(NSRC), .PW(PW), .IW(IW)) u_arb (
      .clk    (clk),
      .rstN   (rstN),
      .qual   (qual[b]),
      .prio   (prio),
      .anyHit (anyHit[b]),
      .winIdx (winIdx[b])
    );

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enMask[b]  <= '0;
        ceil[b]    <= '1;
        bankOut[b] <= 1'b0;
      end else begin
        if (str.enSet[b])       enMask[b] <= enMask[b] | wdata[NSRC-1:0];
        else if (str.enClr[b])  enMask[b] <= enMask[b] & ~wdata[NSRC-1:0];
        if (str.ceilWr[b])      ceil[b]   <= wdata[PW-1:0];
        bankOut[b] <= anyHit[b];
      end
    end

    // R3: a set write leaves every written one in the mask
    a_r3_set_sticks: assert property (@(posedge clk) disable iff (!rstN)
      str.enSet[b] |=> ((enMask[b] & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0])));
    // R3: a clear write leaves no written one in the mask
    a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rstN)
      str.enClr[b] |=> ((enMask[b] & $past(wdata[NSRC-1:0])) == '0));
    // R7: the winner respects the bank ceiling
    a_r7_under_ceiling: assert property (@(posedge clk) disable iff (!rstN)
      anyHit[b] |-> (prio[winIdx[b]] <= ceil[b]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      polSel <= '1;
      stkSel <= '0;
      held   <= '0;
      prio   <= '0;
    end else begin
      if (str.polWr)  polSel <= wdata[NSRC-1:0];
      if (str.stkWr)  stkSel <= wdata[NSRC-1:0];
      if (str.prioWr) prio[str.prioIdx] <= wdata[PW-1:0];
      held <= (((|str.ack) ? '0 : held) | corr) & stkSel;
    end
  end

  always_comb begin
    rdMux = '0;
    unique case (str.rdSel)
      RD_STATUS: rdMux = DW'(qual[str.rdBank]);
      RD_RAW:    rdMux = DW'(corr);
      RD_MASK:   rdMux = DW'(enMask[str.rdBank]);
      RD_CUR:    rdMux = DW'(winIdx[str.rdBank]);
      RD_CEIL:   rdMux = DW'(ceil[str.rdBank]);
      RD_POL:    rdMux = DW'(polSel);
      RD_STK:    rdMux = DW'(stkSel);
      RD_PRIO:   rdMux = DW'(prio[str.prioIdx]);
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdata <= '0;
    else       rdata <= str.rdEn ? rdMux : '0;
  end

  // R6: after an acknowledge only inputs high at that edge remain held
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (|str.ack) |=> (held == $past(corr & stkSel)));
  // R5: a source not selected for latching never gains a held bit
  a_r5_no_hold_unselected: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((held & ~$past(stkSel)) == '0));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int NSRC  = NUM_SRC,
  parameter int AW    = ADDR_W,
  parameter int DW    = DATA_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] srcIn,
  input  logic [AW-1:0]   busAddr,
  input  logic            busWr,
  input  logic            busRd,
  input  logic [DW-1:0]   busWdata,
  output logic [DW-1:0]   busRdata,
  output logic            irqOut,
  output logic            fiqOut
);
  strobe_t               str;
  logic [NUM_BANK-1:0]   bankOut;

  intc_ctrl #(.ADDR_BITS(AW)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .str     (str)
  );

  intc_dp #(.NSRC(NSRC), .PW(PRIO_W), .DW(DW), .NB(NUM_BANK)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .str     (str),
    .srcIn   (srcIn),
    .wdata   (busWdata),
    .rdata   (busRdata),
    .bankOut (bankOut)
  );

  assign irqOut = bankOut[0];
  assign fiqOut = bankOut[1];
endmodule

// File: tb/tb_prio_intc.sv
module tb_prio_intc;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIn = '0;
  logic [9:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut, fiqOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prio_intc dut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  // reference state
  logic [31:0] mPol, mStk, mHeld;
  logic [31:0] mEn [2];
  logic [3:0]  mCeil [2];
  logic [3:0]  mPrio [32];
  logic [31:0] lastExp;

  function automatic logic [31:0] fCorr();
    return srcIn ^ ~mPol;
  endfunction

  function automatic logic [31:0] fQual(int b);
    logic [31:0] q;
    logic [31:0] pend;
    pend = fCorr() | (mHeld & mStk);
    for (int i = 0; i < 32; i++)
      q[i] = pend[i] && mEn[b][i] && (mPrio[i] <= mCeil[b]);
    return q;
  endfunction

  function automatic logic [31:0] fCur(int b);
    logic [31:0] q;
    int best;
    q = fQual(b);
    best = -1;
    for (int i = 0; i < 32; i++)
      if (q[i] && (best < 0 || mPrio[i] < mPrio[best])) best = i;
    return (best < 0) ? 32'd0 : 32'(best);
  endfunction

  function automatic logic [31:0] fRead(logic [9:0] a);
    int b;
    logic [7:0] o;
    b = a[8];
    o = {a[7:2], 2'b00};
    if (a[9] == 1'b0) begin
      case (o)
        8'h00: return fQual(b);
        8'h04: return fCorr();
        8'h08: return mEn[b];
        8'h20, 8'h28: return fCur(b);
        8'h2C: return 32'(mCeil[b]);
        default: return 32'd0;
      endcase
    end else if (a[8] == 1'b0) begin
      if (o == 8'h00) return mPol;
      if (o == 8'h04) return mStk;
      return 32'd0;
    end else begin
      if (!o[7]) return 32'(mPrio[o[6:2]]);
      return 32'd0;
    end
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock with the inputs already driven; model advances with the edge
  task automatic tick();
    logic expIrq, expFiq;
    logic [31:0] nHeld;
    logic isAck;
    logic [7:0] o;
    expIrq = |fQual(0);
    expFiq = |fQual(1);
    lastExp = busRd ? fRead(busAddr) : 32'd0;
    o = {busAddr[7:2], 2'b00};
    isAck = busRd && !busAddr[9] && (o == 8'h28);
    nHeld = ((isAck ? 32'd0 : mHeld) | fCorr()) & mStk;
    @(posedge clk);
    mHeld = nHeld;
    if (busWr) begin
      if (!busAddr[9]) begin
        if (o == 8'h08) mEn[busAddr[8]] = mEn[busAddr[8]] | busWdata;
        if (o == 8'h0C) mEn[busAddr[8]] = mEn[busAddr[8]] & ~busWdata;
        if (o == 8'h2C) mCeil[busAddr[8]] = busWdata[3:0];
      end else if (!busAddr[8]) begin
        if (o == 8'h00) mPol = busWdata;
        if (o == 8'h04) mStk = busWdata;
      end else if (!o[7]) begin
        mPrio[o[6:2]] = busWdata[3:0];
      end
    end
    @(negedge clk);
    busWr = 1'b0;
    busRd = 1'b0;
    check("R9 irqOut", 32'(irqOut), 32'(expIrq));
    check("R9 fiqOut", 32'(fiqOut), 32'(expFiq));
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    tick();
  endtask

  task automatic rdChk(string req, logic [9:0] a, logic [31:0] exp);
    busAddr = a; busRd = 1'b1;
    tick();
    check(req, busRdata, exp);
  endtask

  task automatic rdModel(string req, logic [9:0] a);
    busAddr = a; busRd = 1'b1;
    tick();
    check(req, busRdata, lastExp);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    mPol = '1; mStk = '0; mHeld = '0;
    mEn[0] = '0; mEn[1] = '0; mCeil[0] = 4'hF; mCeil[1] = 4'hF;
    for (int i = 0; i < 32; i++) mPrio[i] = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R2 reset state
    check("R2 irqOut low", 32'(irqOut), 32'd0);
    rdChk("R2 polarity", 10'h200, 32'hFFFF_FFFF);
    rdChk("R2 latch select", 10'h204, 32'd0);
    rdChk("R2 irq mask", 10'h008, 32'd0);
    rdChk("R2 fiq mask", 10'h108, 32'd0);
    rdChk("R2 irq ceiling", 10'h02C, 32'hF);
    rdChk("R2 fiq ceiling", 10'h12C, 32'hF);
    rdChk("R2 priority 31", 10'h37C, 32'd0);
    // R1 unmapped reads and idle data
    rdChk("R1 unmapped 0x380", 10'h380, 32'd0);
    rdChk("R1 unmapped 0x210", 10'h210, 32'd0);
    tick();
    check("R1 idle rdata", busRdata, 32'd0);

    // R4 polarity inversion
    wr(10'h200, 32'hFFFF_FF7F);
    rdChk("R4 raw inverted bit 7", 10'h004, 32'h0000_0080);
    wr(10'h200, 32'hFFFF_FFFF);
    rdChk("R4 raw restored", 10'h104, 32'd0);

    // R3 set and clear
    wr(10'h008, 32'h0000_0220);
    rdChk("R3 mask after set", 10'h008, 32'h0000_0220);
    wr(10'h00C, 32'h0000_0200);
    rdChk("R3 mask after clear", 10'h008, 32'h0000_0020);
    wr(10'h008, 32'h0000_0200);

    // R8 tie and priority order
    srcIn = 32'h0000_0220;
    rdChk("R8 tie goes to lower index", 10'h020, 32'd5);
    check("R9 irq high", 32'(irqOut), 32'd1);
    check("R9 fiq untouched", 32'(fiqOut), 32'd0);
    wr(10'h314, 32'd3);
    wr(10'h324, 32'd1);
    rdChk("R8 smaller value wins", 10'h020, 32'd9);
    rdChk("R10 priority readback", 10'h314, 32'd3);

    // R7 ceiling
    wr(10'h02C, 32'd0);
    rdChk("R7 status under ceiling 0", 10'h000, 32'd0);
    rdChk("R8 none qualifies", 10'h020, 32'd0);
    check("R7 irq dropped", 32'(irqOut), 32'd0);
    wr(10'h02C, 32'd1);
    rdChk("R7 only prio 1 passes", 10'h000, 32'h0000_0200);
    wr(10'h02C, 32'hF);

    // R9 fast bank independent
    rdChk("R9 fiq status empty", 10'h100, 32'd0);
    wr(10'h108, 32'h0000_0200);
    rdChk("R9 fiq current", 10'h120, 32'd9);
    check("R9 fiq high", 32'(fiqOut), 32'd1);
    rdChk("R9 irq mask kept", 10'h008, 32'h0000_0220);

    // R5 latching versus level following
    srcIn = '0;
    wr(10'h008, 32'h0000_0018);
    wr(10'h204, 32'h0000_0008);
    srcIn = 32'h0000_0018;
    tick();
    srcIn = '0;
    tick();
    rdChk("R5 held source pending, level source gone", 10'h000, 32'h0000_0008);
    // R6 acknowledge
    rdChk("R6 ack returns current", 10'h028, 32'd3);
    rdChk("R6 held request cleared", 10'h000, 32'd0);
    srcIn = 32'h0000_0008;
    tick();
    rdChk("R6 ack with input still high", 10'h028, 32'd3);
    rdChk("R6 still pending while input high", 10'h000, 32'h0000_0008);
    srcIn = '0;
    tick();

    // random phase: mixed accesses with pulsing inputs
    for (int n = 0; n < 3000; n++) begin
      int op;
      logic [9:0] bankBase;
      srcIn = $urandom();
      op = $urandom_range(0, 11);
      bankBase = ($urandom_range(0, 1) == 1) ? 10'h100 : 10'h000;
      case (op)
        0: wr(bankBase | 10'h008, $urandom());
        1: wr(bankBase | 10'h00C, $urandom());
        2: wr(bankBase | 10'h02C, $urandom());
        3: wr(10'h200, $urandom() | $urandom());
        4: wr(10'h204, $urandom());
        5: wr(10'h300 | 10'($urandom_range(0, 31) * 4), $urandom());
        6: rdModel("R7 random status", bankBase | 10'h000);
        7: rdModel("R8 random current", bankBase | 10'h020);
        8: rdModel("R6 random ack", bankBase | 10'h028);
        9: rdModel("R4 random raw", bankBase | 10'h004);
        10: rdModel("R3 random mask", bankBase | 10'h008);
        default: tick();
      endcase
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule